// File: doc/BRIEF.md
# Debug Command Register Controller

This block is an 8-bit command data register that sits behind a test access port. An external TAP state machine supplies the capture, shift and update strobes together with the serial data input. The block returns serial data output. A capture strobe loads a live status byte into the shift register. Shift strobes move that status out and move a command byte in, least significant bit first. An update strobe decodes the command that was shifted in.

Decoded commands act on three pieces of device state. The first is a device-reset request, which is merged with an external reset source. The second is a chip-erase handshake toward a flash controller. The third is a latch that allows or blocks processor accesses to flash. The status byte reports these three pieces of state. It also reports configuration readiness, code protection and an NVM error flag, all of which come from outside the block.

Top module: `dbg_cmd_ctrl`

## Requirements
- R1: A clock edge with `capture_dr` high loads the status byte into the shift register. The byte is laid out as follows: bit 7 code-unprotected, bit 5 NVM error, bit 3 configuration ready, bit 2 erase busy, bit 1 flash access enable, bit 0 device reset active. Bits 6 and 4 are always 0.
- R2: A clock edge with `shift_dr` high shifts the register right by one bit and enters `tdi` at bit 7. `tdo` always shows bit 0. After eight shifts, the status byte has left on `tdo` LSB first, and bit 0 of the shifted-in command appears on `tdo`.
- R3: Command 0x00 changes no state. Its only effect is that the status byte was returned.
- R4: Command 0xD1 sets the reset request. `dev_rst_o` is high from the update edge onward.
- R5: Command 0xD0 clears the reset request. `dev_rst_o` is the OR of the reset request and `ext_rst_i`, so it stays high while `ext_rst_i` is high.
- R6: Command 0xFC starts an erase. From the update edge, `erase_req_o` and status bit 2 read 1. They return to 0 at the first clock edge that samples `erase_done_i` high.
- R7: Command 0xFC received while an erase is already busy is ignored. After the erase completes, no new erase starts.
- R8: Command 0xFE sets the flash access latch (`flash_en_o` = 1). Command 0xFD clears it.
- R9: Status bit 7 reads `code_unprot_i` only while `cfg_ready_i` is 1. Otherwise it reads 0.
- R10: Any command code other than 0x00, 0xD0, 0xD1, 0xFC, 0xFD and 0xFE changes no state.
- R11: Synchronous reset clears the reset request, sets the flash access latch, idles the erase handshake and clears the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| capture_dr | input | 1 | Capture strobe from TAP state machine |
| shift_dr | input | 1 | Shift strobe from TAP state machine |
| update_dr | input | 1 | Update strobe from TAP state machine |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of shift register |
| ext_rst_i | input | 1 | External reset source, active high |
| cfg_ready_i | input | 1 | Configuration has been read |
| code_unprot_i | input | 1 | Device not code-protected (valid when configuration ready) |
| nvm_err_i | input | 1 | NVM operation error flag |
| erase_done_i | input | 1 | Flash controller signals erase complete |
| erase_req_o | output | 1 | Erase request, held until completion |
| flash_en_o | output | 1 | Processor flash access enable |
| dev_rst_o | output | 1 | Device reset, OR of all reset requests |

## Verification
The status byte is captured on the capture edge. Its bit k is visible on `tdo` in the half cycle after the capture edge plus k shift edges. The bench therefore reads each bit at the falling edge just before the shift edge that would replace it. Command effects are registered on the update edge, so `dev_rst_o`, `flash_en_o` and `erase_req_o` are compared at the following falling edge against a model that the bench keeps itself. Erase completion is likewise checked one falling edge after the edge that samples `erase_done_i`. All 256 command codes are swept, with the external status inputs varied from one code to the next.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    localparam int DR_W = 8;

    localparam logic [DR_W-1:0] CODE_NOP      = 8'h00;
    localparam logic [DR_W-1:0] CODE_RST_SET  = 8'hD1;
    localparam logic [DR_W-1:0] CODE_RST_CLR  = 8'hD0;
    localparam logic [DR_W-1:0] CODE_ERASE    = 8'hFC;
    localparam logic [DR_W-1:0] CODE_FEN_ON   = 8'hFE;
    localparam logic [DR_W-1:0] CODE_FEN_OFF  = 8'hFD;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_NOP,
        OP_RST_SET,
        OP_RST_CLR,
        OP_ERASE,
        OP_FEN_ON,
        OP_FEN_OFF
    } op_t;

    typedef struct packed {
        logic unprot;
        logic zero6;
        logic nvm_err;
        logic zero4;
        logic cfg_rdy;
        logic busy;
        logic fen;
        logic drst;
    } status_t;

    typedef struct packed {
        logic req;
        logic fen;
        logic busy;
    } dev_state_t;

    function automatic op_t decode_code(input logic [DR_W-1:0] code);
        op_t r;
        case (code)
            CODE_NOP:     r = OP_NOP;
            CODE_RST_SET: r = OP_RST_SET;
            CODE_RST_CLR: r = OP_RST_CLR;
            CODE_ERASE:   r = OP_ERASE;
            CODE_FEN_ON:  r = OP_FEN_ON;
            CODE_FEN_OFF: r = OP_FEN_OFF;
            default:      r = OP_NONE;
        endcase
        return r;
    endfunction

    function automatic status_t build_status(
        input logic       unprot,
        input logic       cfg_rdy,
        input logic       nvm_err,
        input dev_state_t st,
        input logic       drst
    );
        status_t s;
        s.unprot  = unprot & cfg_rdy;
        s.zero6   = 1'b0;
        s.nvm_err = nvm_err;
        s.zero4   = 1'b0;
        s.cfg_rdy = cfg_rdy;
        s.busy    = st.busy;
        s.fen     = st.fen;
        s.drst    = drst;
        return s;
    endfunction

endpackage

// File: rtl/dcc_shift_reg.sv
module dcc_shift_reg #(
    parameter int W = dcc_pkg::DR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic         shift,
    input  logic [W-1:0] load_val,
    input  logic         tdi,
    output logic         tdo,
    output logic [W-1:0] data
);

    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (capture) begin
            sr_q <= load_val;
        end else if (shift) begin
            sr_q <= {tdi, sr_q[W-1:1]};
        end
    end

    assign tdo  = sr_q[0];
    assign data = sr_q;

    p_capture_load_r1: assert property (@(posedge clk) disable iff (rst)
        capture |=> data == $past(load_val));

    p_shift_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (shift && !capture) |=> (data[W-1] == $past(tdi)) && (data[W-2:0] == $past(data[W-1:1])));

endmodule

// File: rtl/dcc_cmd_decode.sv
module dcc_cmd_decode
    import dcc_pkg::*;
#(
    parameter int W = DR_W
) (
    input  logic [W-1:0] code,
    input  logic         update,
    output op_t          op,
    output logic         op_valid
);

    assign op       = decode_code(code);
    assign op_valid = update;

endmodule

// File: rtl/dcc_ctrl_state.sv
module dcc_ctrl_state
    import dcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  op_t        op,
    input  logic       op_valid,
    input  logic       erase_done,
    output dev_state_t st
);

    dev_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.req  <= 1'b0;
            st_q.fen  <= 1'b1;
            st_q.busy <= 1'b0;
        end else begin
            if (st_q.busy && erase_done) begin
                st_q.busy <= 1'b0;
            end
            if (op_valid) begin
                case (op)
                    OP_RST_SET: st_q.req <= 1'b1;
                    OP_RST_CLR: st_q.req <= 1'b0;
                    OP_FEN_ON:  st_q.fen <= 1'b1;
                    OP_FEN_OFF: st_q.fen <= 1'b0;
                    OP_ERASE: begin
                        if (!st_q.busy) begin
                            st_q.busy <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign st = st_q;

    p_rst_set_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_RST_SET) |=> st_q.req);

    p_rst_clr_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_RST_CLR) |=> !st_q.req);

    p_erase_start_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_ERASE && !st_q.busy) |=> st_q.busy);

    p_erase_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && !erase_done) |=> st_q.busy);

    p_erase_end_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && erase_done) |=> !st_q.busy);

    p_fen_on_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_FEN_ON) |=> st_q.fen);

    p_fen_off_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_FEN_OFF) |=> !st_q.fen);

    p_no_effect_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op == OP_NONE || op == OP_NOP) && !(st_q.busy && erase_done))
        |=> $stable(st_q));

endmodule

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl
    import dcc_pkg::*;
#(
    parameter int W = DR_W
) (
    input  logic clk,
    input  logic rst,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic update_dr,
    input  logic tdi,
    output logic tdo,
    input  logic ext_rst_i,
    input  logic cfg_ready_i,
    input  logic code_unprot_i,
    input  logic nvm_err_i,
    input  logic erase_done_i,
    output logic erase_req_o,
    output logic flash_en_o,
    output logic dev_rst_o
);

    logic [W-1:0] dr_q;
    status_t      status;
    op_t          op;
    logic         op_valid;
    dev_state_t   st;

    assign dev_rst_o   = st.req | ext_rst_i;
    assign erase_req_o = st.busy;
    assign flash_en_o  = st.fen;

    assign status = build_status(code_unprot_i, cfg_ready_i, nvm_err_i, st, dev_rst_o);

    dcc_shift_reg #(.W(W)) u_sr (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture_dr),
        .shift    (shift_dr),
        .load_val (status),
        .tdi      (tdi),
        .tdo      (tdo),
        .data     (dr_q)
    );

    dcc_cmd_decode #(.W(W)) u_dec (
        .code     (dr_q),
        .update   (update_dr),
        .op       (op),
        .op_valid (op_valid)
    );

    dcc_ctrl_state u_state (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .op_valid   (op_valid),
        .erase_done (erase_done_i),
        .st         (st)
    );

    p_zero_bits_r1: assert property (@(posedge clk) disable iff (rst)
        capture_dr |=> (dr_q[6] == 1'b0) && (dr_q[4] == 1'b0));

    p_cp_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (capture_dr && !cfg_ready_i) |=> !dr_q[7]);

    p_busy_report_r6: assert property (@(posedge clk) disable iff (rst)
        capture_dr |=> dr_q[2] == $past(erase_req_o));

endmodule

// File: tb/test_dbg_cmd_ctrl.sv
module test_dbg_cmd_ctrl;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic ext_rst_i = 0, cfg_ready_i = 0, code_unprot_i = 0, nvm_err_i = 0, erase_done_i = 0;
    logic tdo, erase_req_o, flash_en_o, dev_rst_o;

    int n_run = 0;
    int n_fail = 0;
    bit done_flag = 0;

    logic m_req = 0, m_fen = 1, m_busy = 0;

    always #(CLK_P/2) clk = ~clk;

    dbg_cmd_ctrl i_dbg_cmd_ctrl (
        .clk(clk), .rst(rst), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .ext_rst_i(ext_rst_i),
        .cfg_ready_i(cfg_ready_i), .code_unprot_i(code_unprot_i), .nvm_err_i(nvm_err_i),
        .erase_done_i(erase_done_i), .erase_req_o(erase_req_o),
        .flash_en_o(flash_en_o), .dev_rst_o(dev_rst_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        logic [7:0] s;
        s = '0;
        s[7] = code_unprot_i & cfg_ready_i;
        s[5] = nvm_err_i;
        s[3] = cfg_ready_i;
        s[2] = m_busy;
        s[1] = m_fen;
        s[0] = m_req | ext_rst_i;
        return s;
    endfunction

    task automatic model_apply(input logic [7:0] c);
        case (c)
            8'hD1: m_req = 1;
            8'hD0: m_req = 0;
            8'hFE: m_fen = 1;
            8'hFD: m_fen = 0;
            8'hFC: if (!m_busy) m_busy = 1;
            default: ;
        endcase
    endtask

    task automatic scan(input logic [7:0] cmd, output logic [7:0] st, output logic tdo_after);
        @(negedge clk); capture_dr = 1;
        @(negedge clk); capture_dr = 0; shift_dr = 1;
        for (int i = 0; i < 8; i++) begin
            if (i > 0) @(negedge clk);
            tdi = cmd[i];
            st[i] = tdo;
        end
        @(negedge clk); shift_dr = 0; update_dr = 1; tdo_after = tdo;
        @(negedge clk); update_dr = 0;
    endtask

    task automatic check_outputs(input string tag);
        chk({tag, " dev_rst_o (R5 OR)"}, dev_rst_o, m_req | ext_rst_i);
        chk({tag, " flash_en_o"}, flash_en_o, m_fen);
        chk({tag, " erase_req_o"}, erase_req_o, m_busy);
    endtask

    task automatic pulse_done();
        @(negedge clk); erase_done_i = 1;
        @(negedge clk); erase_done_i = 0;
        m_busy = 0;
    endtask

    string tag;

    initial begin
        logic [7:0] st;
        logic       ta;
        logic [7:0] es;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11: reset state
        chk("R11 dev_rst_o", dev_rst_o, 0);
        chk("R11 flash_en_o", flash_en_o, 1);
        chk("R11 erase_req_o", erase_req_o, 0);
        chk("R11 tdo", tdo, 0);

        // Sweep all command codes with varied status inputs
        for (int idx = 0; idx < 256; idx++) begin
            if (m_busy && (idx % 5 == 0)) begin
                pulse_done();
                chk("R6 erase done", erase_req_o, 0);
            end
            ext_rst_i     = (idx % 7 == 3);
            cfg_ready_i   = idx[1];
            code_unprot_i = idx[2] | idx[5];
            nvm_err_i     = idx[3];
            es = exp_status();
            scan(idx[7:0], st, ta);
            chk("R1 R2 status byte", st, es);
            chk("R9 code-protect bit", st[7], code_unprot_i & cfg_ready_i);
            chk("R2 command bit0 on tdo", ta, idx[0]);
            case (idx[7:0])
                8'h00: tag = "R3";
                8'hD1: tag = "R4";
                8'hD0: tag = "R5";
                8'hFC: tag = m_busy ? "R7" : "R6";
                8'hFD, 8'hFE: tag = "R8";
                default: tag = "R10";
            endcase
            model_apply(idx[7:0]);
            check_outputs(tag);
        end

        // Directed: reset request merged with external reset (R4, R5)
        ext_rst_i = 0; cfg_ready_i = 1; code_unprot_i = 1; nvm_err_i = 0;
        scan(8'hD1, st, ta); model_apply(8'hD1);
        chk("R4 dev_rst_o after set", dev_rst_o, 1);
        ext_rst_i = 1;
        scan(8'hD0, st, ta); model_apply(8'hD0);
        chk("R5 dev_rst_o held by external", dev_rst_o, 1);
        chk("R5 status bit0 before clear", st[0], 1);
        @(negedge clk); ext_rst_i = 0;
        #1;
        chk("R5 dev_rst_o released", dev_rst_o, 0);

        // Directed: erase busy, repeat ignored (R6, R7)
        if (m_busy) pulse_done();
        scan(8'hFC, st, ta); model_apply(8'hFC);
        chk("R6 erase started", erase_req_o, 1);
        scan(8'hFC, st, ta); model_apply(8'hFC);
        chk("R7 status busy during repeat", st[2], 1);
        chk("R7 erase still busy", erase_req_o, 1);
        pulse_done();
        chk("R7 busy cleared after done", erase_req_o, 0);
        repeat (3) @(negedge clk);
        chk("R7 no restart", erase_req_o, 0);
        scan(8'h00, st, ta);
        chk("R7 status busy clear", st[2], 0);
        check_outputs("R3");

        // Directed: flash latch toggles (R8)
        scan(8'hFD, st, ta); model_apply(8'hFD);
        chk("R8 disable", flash_en_o, 0);
        scan(8'h5A, st, ta);
        chk("R10 latch unchanged", flash_en_o, 0);
        chk("R8 status fen low", st[1], 0);
        scan(8'hFE, st, ta); model_apply(8'hFE);
        chk("R8 enable", flash_en_o, 1);

        if (!done_flag) begin
            done_flag = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done_flag) begin
            done_flag = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule